// File: doc/BRIEF.md
# LED Open-Circuit Test Sequencer

This block sequences the self-test of a multi-channel LED current-sink driver. On the pin side it takes a test input (`tst_in`) and drives a result output (`tst_out`). After power-on reset the block waits in a ready state. The first high level on the test input returns the device health bit. A following train of low-high pulses then walks the LED channels one by one. During each high phase the output shows whether the LED on the selected channel is attached. One more pulse after the last channel closes the test.

The same channel walk can be started through a register port. A write of the start code to the test register starts the run, but only while both the active-mode and boost-enable control bits are set. The run then moves one channel per serial-clock strobe (`scl_tick`) and collects one pass bit per channel plus a completion flag. Software reads these back from the same register address. The per-channel connected flags (`led_ok`) and the device health bit (`self_ok`) are synchronous inputs from the analog side.

States: `ST_READY` (idle), `ST_ACK` (health acknowledged), `ST_CHAN` (pin-paced channel walk), `ST_DEAD` (health failed, locked until reset), `ST_FIELD` (register-started walk). Transitions:
- READY→ACK on a test-input rise with `self_ok`=1.
- READY→DEAD on a rise with `self_ok`=0.
- READY→FIELD on a valid start write.
- ACK→CHAN on a rise.
- CHAN→CHAN on a rise before the last channel.
- CHAN→READY on the rise after the last channel.
- FIELD→READY on the strobe that captures the last channel.

Top module: `led_open_probe`

## Requirements
- R1: While the test input has been low for three clock edges, `tst_out` is 0. A change on `tst_in` reaches `tst_out` after three rising clock edges: two synchronizer flops plus the state register.
- R2: Out of reset `tst_out` is 0 and the block is ready. The first rise of the test input with `self_ok`=1 makes `tst_out` 1 for that high phase.
- R3: If `self_ok` is 0 at the first rise, `tst_out` stays 0 on every later high phase until reset. A reset lets a new acknowledge be given.
- R4: After an acknowledge, rises 1 to NCH select channels 0 to NCH-1 in order. During the high phase, `tst_out` equals `led_ok[channel]`.
- R5: Rise NCH+1 after the acknowledge ends the test: `tst_out` is 0 in that phase and the block returns to ready. The next rise gives a fresh acknowledge.
- R6: A write with `reg_addr`=0x0C and `reg_wdata`=0x01 while in ready, with `mode_active`=1 and `mode_boost`=1, starts a field run and clears the result register to 0x00.
- R7: A start write is ignored if either mode bit is 0, the data is not 0x01, or the address is not 0x0C. The result register is then left unchanged.
- R8: In a field run, strobe k+1 (k from 0) stores `led_ok[k]` into result bit k. Strobe NCH also sets the done bit and returns the block to ready.
- R9: A read (`reg_rd`=1) at 0x0C returns bit 7 = done and bits NCH-1..0 = pass bits, with the other bits 0. Any other address, or `reg_rd`=0, returns 0.
- R10: If a test-input rise in ready and a valid start write fall in the same cycle, the pin test wins: an acknowledge is given and the write is dropped.
- R11: During a field run the test input is ignored: `tst_out` stays 0 and the run completes with correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| tst_in | input | 1 | Asynchronous test input pin |
| self_ok | input | 1 | Device health result |
| led_ok | input | NCH | Per-channel LED connected flags |
| mode_active | input | 1 | Active (not standby) control bit |
| mode_boost | input | 1 | Boost-enable control bit |
| scl_tick | input | 1 | One-cycle strobe per serial-bus clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| tst_out | output | 1 | Test result pin |

## Verification
A synchronized rise of the test input while in ready can fall in the same cycle as a valid start write. The bench forces this by raising the pin and issuing the write exactly two clock edges later, when the synchronized edge is present. The outcome is judged at the ports. An acknowledge must appear on `tst_out`. The result register must still hold the value of the previous field run after five serial strobes. The rest of the pin test must then run normally.

// File: rtl/led_probe_pkg.sv
package led_probe_pkg;
    typedef enum logic [2:0] {
        ST_READY = 3'd0,
        ST_ACK   = 3'd1,
        ST_CHAN  = 3'd2,
        ST_DEAD  = 3'd3,
        ST_FIELD = 3'd4
    } probe_state_e;
endpackage

// File: rtl/probe_sync.sv
module probe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[0] <= 1'b0;
                    else        sh[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[g] <= 1'b0;
                    else        sh[g] <= sh[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sh[STAGES-1];
    end

    assign level = sh[STAGES-1];
    assign rise  = sh[STAGES-1] & ~prev;

    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/field_store.sv
module field_store #(
    parameter int NCH = 5,
    parameter int IW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           cap,
    input  logic [IW-1:0]  cap_idx,
    input  logic           cap_val,
    input  logic           fin,
    output logic [NCH-1:0] pass,
    output logic           done
);
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             pass[g] <= 1'b0;
                else if (clr)                           pass[g] <= 1'b0;
                else if (cap && cap_idx == IW'(g))      pass[g] <= cap_val;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   done <= 1'b0;
        else if (clr) done <= 1'b0;
        else if (fin) done <= 1'b1;
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done && pass == '0));
    assert_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !clr) |=> done);
endmodule

// File: rtl/led_open_probe.sv
module led_open_probe
    import led_probe_pkg::*;
#(
    parameter int         NCH        = 5,
    parameter int         AW         = 8,
    parameter int         DW         = 8,
    parameter int         SYNC_STG   = 2,
    parameter logic [7:0] REG_ADDR   = 8'h0C,
    parameter logic [7:0] START_CODE = 8'h01
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tst_in,
    input  logic           self_ok,
    input  logic [NCH-1:0] led_ok,
    input  logic           mode_active,
    input  logic           mode_boost,
    input  logic           scl_tick,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           tst_out
);
    localparam int          IW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [IW-1:0] LAST = IW'(NCH - 1);

    probe_state_e  state, state_nx;
    logic [IW-1:0] ch_idx;
    logic          t1_lvl, t1_rise;
    logic          start_ok, res_bit;
    logic          f_clr, f_cap, f_fin;
    logic [NCH-1:0] f_pass;
    logic          f_done;

    probe_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (tst_in),
        .level (t1_lvl),
        .rise  (t1_rise)
    );

    assign start_ok = reg_wr && (reg_addr == AW'(REG_ADDR)) &&
                      (reg_wdata == DW'(START_CODE)) &&
                      mode_active && mode_boost && !t1_rise;

    // next-state process
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: begin
                if (t1_rise)       state_nx = self_ok ? ST_ACK : ST_DEAD;
                else if (start_ok) state_nx = ST_FIELD;
            end
            ST_ACK:   if (t1_rise) state_nx = ST_CHAN;
            ST_CHAN:  if (t1_rise && ch_idx == LAST) state_nx = ST_READY;
            ST_DEAD:  state_nx = ST_DEAD;
            ST_FIELD: if (scl_tick && ch_idx == LAST) state_nx = ST_READY;
            default:  state_nx = ST_READY;
        endcase
    end

    // state register and channel pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_READY;
            ch_idx <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_READY: if (start_ok && !t1_rise) ch_idx <= '0;
                ST_ACK:   if (t1_rise) ch_idx <= '0;
                ST_CHAN:  if (t1_rise && ch_idx != LAST) ch_idx <= ch_idx + 1'b1;
                ST_FIELD: if (scl_tick && ch_idx != LAST) ch_idx <= ch_idx + 1'b1;
                default:  ch_idx <= ch_idx;
            endcase
        end
    end

    // output process
    always_comb begin
        res_bit = 1'b0;
        f_clr   = 1'b0;
        f_cap   = 1'b0;
        f_fin   = 1'b0;
        unique case (state)
            ST_READY: f_clr = start_ok;
            ST_ACK:   res_bit = 1'b1;
            ST_CHAN:  res_bit = led_ok[ch_idx];
            ST_FIELD: begin
                f_cap = scl_tick;
                f_fin = scl_tick && (ch_idx == LAST);
            end
            default:  res_bit = 1'b0;
        endcase
        tst_out = t1_lvl & res_bit;
    end

    field_store #(.NCH(NCH), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (f_clr),
        .cap     (f_cap),
        .cap_idx (ch_idx),
        .cap_val (led_ok[ch_idx]),
        .fin     (f_fin),
        .pass    (f_pass),
        .done    (f_done)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && reg_addr == AW'(REG_ADDR)) begin
            reg_rdata[NCH-1:0] = f_pass;
            reg_rdata[DW-1]    = f_done;
        end
    end

    assert_t2_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tst_in && $past(!tst_in) && $past(!tst_in, 2)) |-> !tst_out);
    assert_dead_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEAD) |-> !tst_out);
    assert_dead_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEAD) |=> (state == ST_DEAD));
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ch_idx <= LAST);
    assert_end_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_CHAN && state != ST_CHAN) |-> (state == ST_READY));
    assert_field_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_FIELD) |-> $past(mode_active && mode_boost && reg_wr));
    assert_pin_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && t1_rise) |=> (state != ST_FIELD));
    assert_field_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIELD) |-> !tst_out);
endmodule

// File: tb/led_open_probe_tb_top.sv
`timescale 1ns/1ps
module led_open_probe_tb_top;
    localparam int NCH = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tst_in = 1'b0;
    logic           self_ok = 1'b1;
    logic [NCH-1:0] led_ok = '0;
    logic           mode_active = 1'b1;
    logic           mode_boost = 1'b1;
    logic           scl_tick = 1'b0;
    logic           reg_wr = 1'b0;
    logic           reg_rd = 1'b0;
    logic [7:0]     reg_addr = 8'h00;
    logic [7:0]     reg_wdata = 8'h00;
    logic [7:0]     reg_rdata;
    logic           tst_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    led_open_probe #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .tst_in(tst_in), .self_ok(self_ok),
        .led_ok(led_ok), .mode_active(mode_active), .mode_boost(mode_boost),
        .scl_tick(scl_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tst_out(tst_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input string tag, input int exp_hi);
        @(negedge clk); tst_in = 1'b1;
        repeat (4) @(negedge clk);
        check(tag, int'(tst_out), exp_hi);
        tst_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 low phase", int'(tst_out), 0);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); scl_tick = 1'b1;
        @(negedge clk); scl_tick = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 check(tag, int'(reg_rdata), exp);
        reg_rd = 1'b0;
    endtask

    function automatic int field_val(input int p, input int k);
        int m;
        m = (1 << (k + 1)) - 1;
        return (p & m) | ((k == NCH - 1) ? 8'h80 : 0);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        check("R2 reset tst_out", int'(tst_out), 0);
        rd_chk("R9 reset register", 8'h0C, 0);

        // R2 R4 R5: full pin sweep over every connection pattern
        for (int p = 0; p < (1 << NCH); p++) begin
            led_ok = NCH'(p);
            pulse(p == 0 ? "R2 acknowledge" : "R5 fresh acknowledge", 1);
            for (int c = 0; c < NCH; c++)
                pulse("R4 channel result", (p >> c) & 1);
            pulse("R5 end pulse", 0);
        end

        // R6 R8: field runs over every pattern
        for (int p = 0; p < (1 << NCH); p++) begin
            led_ok = NCH'(p);
            wr_reg(8'h0C, 8'h01);
            rd_chk("R6 cleared at start", 8'h0C, 0);
            for (int k = 0; k < NCH; k++) begin
                tick();
                rd_chk("R8 field step", 8'h0C, field_val(p, k));
            end
        end

        // R9 read decode
        rd_chk("R9 other address", 8'h0D, 0);
        @(negedge clk); reg_rd = 1'b0; reg_addr = 8'h0C;
        #1 check("R9 no read enable", int'(reg_rdata), 0);

        // R7 rejected starts, register holds 0x9F
        led_ok = '0;
        mode_active = 1'b0; wr_reg(8'h0C, 8'h01);
        for (int k = 0; k < NCH; k++) tick();
        rd_chk("R7 active bit low", 8'h0C, 8'h9F);
        mode_active = 1'b1; mode_boost = 1'b0; wr_reg(8'h0C, 8'h01);
        for (int k = 0; k < NCH; k++) tick();
        rd_chk("R7 boost bit low", 8'h0C, 8'h9F);
        mode_boost = 1'b1; wr_reg(8'h0C, 8'h02);
        for (int k = 0; k < NCH; k++) tick();
        rd_chk("R7 wrong code", 8'h0C, 8'h9F);
        wr_reg(8'h0D, 8'h01);
        for (int k = 0; k < NCH; k++) tick();
        rd_chk("R7 wrong address", 8'h0C, 8'h9F);

        // R11 pin activity during a field run
        led_ok = 5'b01010;
        wr_reg(8'h0C, 8'h01);
        tick(); tick();
        pulse("R11 pin ignored in run", 0);
        for (int k = 2; k < NCH; k++) tick();
        rd_chk("R11 run completes", 8'h0C, 8'h8A);

        // R10 same-cycle pin rise and start write
        led_ok = 5'b10101;
        @(negedge clk); tst_in = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 8'h0C; reg_wdata = 8'h01;
        @(negedge clk); reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 pin acknowledge wins", int'(tst_out), 1);
        tst_in = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < NCH; k++) tick();
        rd_chk("R10 write dropped", 8'h0C, 8'h8A);
        for (int c = 0; c < NCH; c++)
            pulse("R10 pin walk after collision", (5'b10101 >> c) & 1);
        pulse("R5 end after collision", 0);

        // R3 failed health lock
        self_ok = 1'b0;
        pulse("R3 failed acknowledge", 0);
        self_ok = 1'b1;
        led_ok = '1;
        for (int c = 0; c < NCH + 1; c++)
            pulse("R3 locked low", 0);
        do_reset();
        pulse("R3 acknowledge after reset", 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule